// File: doc/BRIEF.md
# Configuration Memory Security Lock

This controller keeps the security state of a serial configuration memory and decides which accesses reach the memory array. A serial front end, not part of this block, decodes bus traffic and hands over simple events: one written byte with its 24-bit address, the end of a write message, a read request, an explicit chip-erase command and a power-cycle pulse. The block returns the lock flag, a readout-enable for the data driver, a write strobe passed on to the array, an erase request with an erase-busy flag, and the reply byte for every read.

A four-byte security window at byte addresses 0x800000 to 0x800003 (byte index in address bits [1:0]) works as a command port. A message that leaves all four window bytes at 0xFF sets the lock. Clearing the lock is deliberately hard. Every message that leaves all four bytes at 0x00 while locked starts a full-array erase. The erase that follows the second such message, with no power cycle in between, also clears the lock when it finishes. The lock is non-volatile, so a power cycle only discards partial unlock progress.

Reads of the window return a status byte, 0xFF when locked and 0x00 when unlocked. While locked, or while an erase runs, reads of the array are refused and writes to the array are blocked. The erase length is a cycle-count parameter, 25 ms at the intended clock by default.

Top module: `cfg_sec_lock`

## Requirements
- R1: A message whose bytes leave all four window bytes at 0xFF, ended by msg_end_i while no erase runs, sets locked_o from the next clock.
- R2: A message that writes only some window bytes, or leaves a mix of values in them, changes neither locked_o nor the unlock progress, and starts no erase.
- R3: The second all-0x00 window message sent while locked, with no power cycle after the first, starts an erase. locked_o stays high during that erase and falls in the cycle erase_busy_o falls.
- R4: Every all-0x00 window message while locked starts an erase: erase_o pulses and erase_busy_o rises the next clock. After the erase started by the first message, locked_o is still high.
- R5: While locked, readout_en_o is 0, arr_we_o stays 0, and an array read (outside the window) replies rd_ack_o=0 with rd_data_o=0x00.
- R6: One clock after rd_req_i, rd_valid_o pulses. A window read replies rd_ack_o=1 with rd_data_o=0xFF when locked and 0x00 when unlocked.
- R7: erase_busy_o stays high for exactly ERASE_CYCLES clocks. During that time window messages are ignored and arr_we_o and readout_en_o stay 0.
- R8: A power-cycle pulse leaves locked_o unchanged and discards any partial unlock progress.
- R9: erase_req_i is accepted when locked. It runs a full erase and leaves locked_o unchanged.
- R10: When unlocked and idle, readout_en_o is 1, array writes pass to arr_we_o in the same cycle, and an array read replies rd_ack_o=1 with the arr_rdata_i value from the request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | A decoded write byte is present |
| wr_addr_i | input | 24 | Byte address of the write |
| wr_data_i | input | 8 | Write data byte |
| msg_end_i | input | 1 | End of the current write message |
| rd_req_i | input | 1 | Read request |
| rd_addr_i | input | 24 | Byte address of the read |
| arr_rdata_i | input | 8 | Array data at rd_addr_i in the request cycle |
| pwr_cycle_i | input | 1 | Power-cycle pulse |
| erase_req_i | input | 1 | Explicit chip-erase command |
| locked_o | output | 1 | Security lock state |
| readout_en_o | output | 1 | Array data may be driven out |
| arr_we_o | output | 1 | Write strobe forwarded to the array |
| erase_o | output | 1 | One-cycle full-array erase request |
| erase_busy_o | output | 1 | Erase in progress |
| rd_valid_o | output | 1 | Read reply valid |
| rd_ack_o | output | 1 | Read accepted |
| rd_data_o | output | 8 | Read reply byte |

## Verification
If the unlock progress counter were wrong, locked_o would fall too early or too late. Each erase takes ERASE_CYCLES cycles, so this shows only after an erase finishes. The bench therefore counts erases and watches lock state across a power cycle and across a window message sent during an erase. A stale lock or busy state shows at once, one clock after any read, as a wrong rd_ack_o or status byte, and in the same cycle as any array write, as a wrong arr_we_o. An erase counter that is off by one shows as a wrong erase_busy_o pulse length.

// File: rtl/cfg_sec_pkg.sv
package cfg_sec_pkg;
  localparam int ADDR_W    = 24;
  localparam int WIN_BYTES = 4;
  localparam int IDX_W     = $clog2(WIN_BYTES);
  localparam logic [ADDR_W-1:0] WIN_BASE = 24'h800000;

  typedef enum logic [1:0] {
    PAT_NONE  = 2'd0,
    PAT_LOCK  = 2'd1,
    PAT_CLEAR = 2'd2
  } pattern_e;

  function automatic logic in_window(input logic [ADDR_W-1:0] addr);
    return (addr >> IDX_W) == (WIN_BASE >> IDX_W);
  endfunction
endpackage

// File: rtl/cfg_sec_win_track.sv
module cfg_sec_win_track
  import cfg_sec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              msg_end_i,
  input  logic              flush_i,
  input  logic              hold_i,
  output pattern_e          pat_o
);
  logic [WIN_BYTES-1:0] ones_q, zeros_q;
  logic                 hit;
  logic                 clr;

  assign hit = wr_valid_i && in_window(wr_addr_i) && !hold_i;
  assign clr = msg_end_i || flush_i;

  for (genvar b = 0; b < WIN_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ones_q[b]  <= 1'b0;
        zeros_q[b] <= 1'b0;
      end else if (clr) begin
        ones_q[b]  <= 1'b0;
        zeros_q[b] <= 1'b0;
      end else if (hit && (wr_addr_i[IDX_W-1:0] == IDX_W'(b))) begin
        // last write to a byte wins
        ones_q[b]  <= (wr_data_i == 8'hFF);
        zeros_q[b] <= (wr_data_i == 8'h00);
      end
    end
  end

  always_comb begin
    pat_o = PAT_NONE;
    if (msg_end_i && !flush_i && !hold_i) begin
      if (&ones_q)       pat_o = PAT_LOCK;
      else if (&zeros_q) pat_o = PAT_CLEAR;
    end
  end
endmodule

// File: rtl/cfg_sec_unlock_seq.sv
module cfg_sec_unlock_seq #(
  parameter int CLEAR_PASSES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_pass_i,
  input  logic locked_i,
  input  logic pwr_cycle_i,
  output logic attempt_o,
  output logic final_o
);
  localparam int CNT_W = $clog2(CLEAR_PASSES + 1);

  logic [CNT_W-1:0] cnt_q;

  assign attempt_o = clear_pass_i && locked_i;
  assign final_o   = attempt_o && (cnt_q == CNT_W'(CLEAR_PASSES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (pwr_cycle_i) cnt_q <= '0;
    else if (!locked_i)   cnt_q <= '0;
    else if (attempt_o)   cnt_q <= final_o ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(CLEAR_PASSES)); // R3
  AST_PWR_DROPS_PROGRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_cycle_i |=> cnt_q == '0); // R8
endmodule

// File: rtl/cfg_sec_erase_timer.sv
module cfg_sec_erase_timer #(
  parameter int ERASE_CYCLES = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic erase_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, pulse_q;

  assign busy_o  = busy_q;
  assign erase_o = pulse_q;
  assign done_o  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      pulse_q <= start_i;
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(ERASE_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R7
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 |=> busy_q); // R7
  AST_PULSE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_o |-> busy_q); // R4
endmodule

// File: rtl/cfg_sec_lock.sv
module cfg_sec_lock
  import cfg_sec_pkg::*;
#(
  parameter int   ERASE_CYCLES = 2_500_000,
  parameter int   CLEAR_PASSES = 2,
  parameter logic LOCK_INIT    = 1'b0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_valid_i,
  input  logic [23:0] wr_addr_i,
  input  logic [7:0]  wr_data_i,
  input  logic        msg_end_i,
  input  logic        rd_req_i,
  input  logic [23:0] rd_addr_i,
  input  logic [7:0]  arr_rdata_i,
  input  logic        pwr_cycle_i,
  input  logic        erase_req_i,
  output logic        locked_o,
  output logic        readout_en_o,
  output logic        arr_we_o,
  output logic        erase_o,
  output logic        erase_busy_o,
  output logic        rd_valid_o,
  output logic        rd_ack_o,
  output logic [7:0]  rd_data_o
);
  pattern_e pat;
  logic     attempt, final_pass, busy, done, start;
  logic     locked_q, clr_pend_q;
  logic     rd_valid_q, rd_ack_q;
  logic [7:0] rd_data_q;
  logic     open_w, rd_win;

  cfg_sec_win_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .msg_end_i  (msg_end_i),
    .flush_i    (pwr_cycle_i),
    .hold_i     (busy),
    .pat_o      (pat)
  );

  cfg_sec_unlock_seq #(.CLEAR_PASSES(CLEAR_PASSES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_pass_i (pat == PAT_CLEAR),
    .locked_i     (locked_q),
    .pwr_cycle_i  (pwr_cycle_i),
    .attempt_o    (attempt),
    .final_o      (final_pass)
  );

  assign start = !busy && (attempt || erase_req_i);

  cfg_sec_erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .erase_o (erase_o),
    .busy_o  (busy),
    .done_o  (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q   <= LOCK_INIT;
      clr_pend_q <= 1'b0;
    end else begin
      if (done) begin
        clr_pend_q <= 1'b0;
        if (clr_pend_q) locked_q <= 1'b0;
      end else begin
        if (pat == PAT_LOCK)       locked_q   <= 1'b1;
        if (final_pass && !busy)   clr_pend_q <= 1'b1;
      end
    end
  end

  assign open_w = !locked_q && !busy;
  assign rd_win = in_window(rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_ack_q   <= 1'b0;
      rd_data_q  <= 8'h00;
    end else begin
      rd_valid_q <= rd_req_i;
      if (rd_req_i) begin
        rd_ack_q  <= rd_win || open_w;
        rd_data_q <= rd_win ? {8{locked_q}} : (open_w ? arr_rdata_i : 8'h00);
      end
    end
  end

  assign locked_o     = locked_q;
  assign readout_en_o = open_w;
  assign arr_we_o     = wr_valid_i && !in_window(wr_addr_i) && open_w;
  assign erase_busy_o = busy;
  assign rd_valid_o   = rd_valid_q;
  assign rd_ack_o     = rd_ack_q;
  assign rd_data_o    = rd_data_q;

  AST_UNLOCK_AT_ERASE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $fell(busy)); // R3
  AST_PEND_IN_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clr_pend_q) |-> busy); // R3
  AST_PWR_KEEPS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_cycle_i && !busy |=> locked_q == $past(locked_q)); // R8
  AST_REFUSED_NO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ack_o |-> rd_data_o == 8'h00); // R5
  AST_START_TO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy && erase_o); // R4
endmodule

// File: tb/sim_cfg_sec_lock.sv
`timescale 1ns/1ps
module sim_cfg_sec_lock;
  localparam int EC = 20;
  localparam logic [23:0] WIN = 24'h800000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_valid_i = 0, msg_end_i = 0, rd_req_i = 0, pwr_cycle_i = 0, erase_req_i = 0;
  logic [23:0] wr_addr_i = '0, rd_addr_i = '0;
  logic [7:0]  wr_data_i = '0, arr_rdata_i = '0;
  logic locked_o, readout_en_o, arr_we_o, erase_o, erase_busy_o;
  logic rd_valid_o, rd_ack_o;
  logic [7:0] rd_data_o;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  cfg_sec_lock #(.ERASE_CYCLES(EC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .msg_end_i(msg_end_i), .rd_req_i(rd_req_i),
    .rd_addr_i(rd_addr_i), .arr_rdata_i(arr_rdata_i), .pwr_cycle_i(pwr_cycle_i),
    .erase_req_i(erase_req_i), .locked_o(locked_o), .readout_en_o(readout_en_o),
    .arr_we_o(arr_we_o), .erase_o(erase_o), .erase_busy_o(erase_busy_o),
    .rd_valid_o(rd_valid_o), .rd_ack_o(rd_ack_o), .rd_data_o(rd_data_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid_i = 1; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic endmsg();
    @(negedge clk);
    wr_valid_i = 0; msg_end_i = 1;
    @(negedge clk);
    msg_end_i = 0;
  endtask

  task automatic win_msg(input logic [31:0] d, input int n);
    for (int i = 0; i < n; i++) put(WIN + 24'(i), d[8*i +: 8]);
    endmsg();
  endtask

  task automatic rd(input logic [23:0] a, output logic ack, output logic [7:0] data);
    @(negedge clk);
    rd_req_i = 1; rd_addr_i = a;
    @(negedge clk);
    rd_req_i = 0;
    check("R6 rd_valid", rd_valid_o, 1);
    ack = rd_ack_o; data = rd_data_o;
  endtask

  task automatic pulse_pwr();
    @(negedge clk); pwr_cycle_i = 1;
    @(negedge clk); pwr_cycle_i = 0;
  endtask

  task automatic wait_erase(output int n);
    n = 0;
    while (erase_busy_o && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    check("R10 reset locked", locked_o, 0);
    check("R7 reset busy", erase_busy_o, 0);
    check("R10 reset readout_en", readout_en_o, 1);
  endtask

  task automatic t_open();
    logic a; logic [7:0] d;
    arr_rdata_i = 8'h5A;
    rd(24'h000010, a, d);
    check("R10 open ack", a, 1);
    check("R10 open data", d, 8'h5A);
    put(24'h000010, 8'h33); #1;
    check("R10 open arr_we", arr_we_o, 1);
    endmsg();
    rd(WIN + 24'd2, a, d);
    check("R6 status ack", a, 1);
    check("R6 status unlocked", d, 8'h00);
  endtask

  task automatic t_partial();
    win_msg(32'hFFFFFFFF, 3);
    check("R2 partial lock", locked_o, 0);
    win_msg(32'hFF00FFFF, 4);
    check("R2 mixed lock", locked_o, 0);
  endtask

  task automatic t_lock();
    logic a; logic [7:0] d;
    win_msg(32'hFFFFFFFF, 4);
    check("R1 locked", locked_o, 1);
    check("R1 no erase", erase_busy_o, 0);
    rd(WIN, a, d);
    check("R6 status locked", d, 8'hFF);
    rd(24'h000010, a, d);
    check("R5 array ack", a, 0);
    check("R5 array data", d, 8'h00);
    check("R5 readout_en", readout_en_o, 0);
    put(24'h000020, 8'h11); #1;
    check("R5 arr_we", arr_we_o, 0);
    endmsg();
  endtask

  task automatic t_partial_locked();
    win_msg(32'h00000000, 3);
    check("R2 partial clear busy", erase_busy_o, 0);
    win_msg(32'h00010000, 4);
    check("R2 mixed clear busy", erase_busy_o, 0);
    check("R2 still locked", locked_o, 1);
  endtask

  task automatic t_first_clear();
    int n;
    win_msg(32'h00000000, 4);
    check("R4 erase pulse", erase_o, 1);
    check("R4 busy", erase_busy_o, 1);
    check("R4 locked during", locked_o, 1);
    wait_erase(n);
    check("R7 erase length", n, EC);
    check("R4 locked after first", locked_o, 1);
  endtask

  task automatic t_pwr_then_ignored();
    int n;
    pulse_pwr();
    check("R8 lock kept", locked_o, 1);
    win_msg(32'h00000000, 4);
    check("R8 erase after pwr", erase_busy_o, 1);
    win_msg(32'h00000000, 4);        // lands inside the erase
    put(24'h000030, 8'h44); #1;
    check("R7 arr_we busy", arr_we_o, 0);
    check("R7 readout_en busy", readout_en_o, 0);
    endmsg();
    wait_erase(n);
    check("R8 progress dropped", locked_o, 1);
  endtask

  task automatic t_unlock();
    int n; logic a; logic [7:0] d;
    win_msg(32'h00000000, 4);
    check("R3 erase started", erase_busy_o, 1);
    check("R3 locked during", locked_o, 1);
    wait_erase(n);
    check("R3 erase length", n, EC);
    check("R3 unlocked at end", locked_o, 0);
    rd(WIN + 24'd3, a, d);
    check("R6 status after unlock", d, 8'h00);
    check("R10 readout_en after", readout_en_o, 1);
  endtask

  task automatic t_chip_erase();
    int n;
    win_msg(32'hFFFFFFFF, 4);
    check("R1 relock", locked_o, 1);
    pulse_pwr();
    check("R8 lock kept again", locked_o, 1);
    @(negedge clk); erase_req_i = 1;
    @(negedge clk); erase_req_i = 0;
    check("R9 erase accepted", erase_busy_o, 1);
    wait_erase(n);
    check("R9 erase length", n, EC);
    check("R9 lock unchanged", locked_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_open();
    t_partial();
    t_lock();
    t_partial_locked();
    t_first_clear();
    t_pwr_then_ignored();
    t_unlock();
    t_chip_erase();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule